// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block turns a request for a data-memory access into an effective address, using one of three 16-bit pointers held inside it. The pointers are named X, Y and Z. Each one is a pair of byte registers taken from the register numbers 26 to 31, and the even-numbered register of each pair is the low byte. A request carries an addressing mode, a pointer select and a 6-bit unsigned displacement. It is launched by a one-cycle start strobe.

There are four modes. The first gives the pointer as it stands. The second decrements the pointer and uses the new value. The third uses the old value and then increments the pointer. The fourth adds the displacement to Y or Z and does not touch the pointer. One cycle after the strobe, the block presents the effective address, the pointer value to be written back and a flag that says whether the pointer really changed. A byte-wide load port addressed by register number fills the pointers before use.

Top module: `dag_top`

## Requirements
- R1: While reset is asserted and after it is released, valid_o, err_o and wb_en_o are 0, ea_o and wb_o are 0, and all three pointers read as 0x0000.
- R2: When ld_en_i is high and start_i is low, the byte ld_byte_i is written into register number ld_reg_i. X is {r27,r26}, Y is {r29,r28} and Z is {r31,r30}, each with the even register as the low byte. Writing one byte leaves the other byte of the pair unchanged.
- R3: A load to a register number outside 26..31 has no effect, and a load in the same cycle as start_i is ignored.
- R4: Mode code 0 (plain): ea_o and wb_o equal the selected pointer, wb_en_o is 0, and the pointer is unchanged.
- R5: Mode code 1 (pre-decrement): the pointer becomes its value minus 1, modulo 2^16. ea_o and wb_o both carry the new value and wb_en_o is 1, so 0x0000 gives 0xFFFF.
- R6: Mode code 2 (post-increment): ea_o is the value before the update. The pointer and wb_o become that value plus 1, modulo 2^16, and wb_en_o is 1, so 0xFFFF gives 0x0000.
- R7: Mode code 3 (displacement): ea_o is Y or Z plus the zero-extended disp_i, modulo 2^16. wb_o is the unchanged pointer, wb_en_o is 0, and the pointer is not modified.
- R8: Select codes are 0 = X, 1 = Y, 2 = Z. A request that selects X in mode 3, or uses select code 3 in any mode, gives err_o = 1, ea_o = 0 and wb_en_o = 0, and leaves every pointer unchanged.
- R9: valid_o is a one-cycle pulse that appears exactly one cycle after each start_i cycle. err_o, ea_o, wb_o, wb_en_o and wb_sel_o belong to that same cycle, and wb_sel_o echoes the select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one address request |
| mode_i | input | 2 | Mode: 0 plain, 1 pre-decrement, 2 post-increment, 3 displacement |
| sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 invalid |
| disp_i | input | 6 | Unsigned displacement used in mode 3 |
| ld_en_i | input | 1 | Byte load enable |
| ld_reg_i | input | 5 | Register number for the load (26..31 used) |
| ld_byte_i | input | 8 | Byte to load |
| valid_o | output | 1 | Result pulse, one cycle after start_i |
| err_o | output | 1 | Request was illegal |
| ea_o | output | 16 | Effective address |
| wb_o | output | 16 | Pointer value after the request |
| wb_en_o | output | 1 | Pointer was modified by the request |
| wb_sel_o | output | 2 | Select code of the request |

## Verification
The assertions assume that start_i and every load input are low while reset is asserted. They also assume that mode_i and sel_i hold known values in any cycle where start_i is high, because the checks look one cycle back at those inputs. The bench changes every input only on the falling clock edge. It keeps start_i low during reset, and the only time it raises start_i together with a load is in the one scenario that exercises that collision.

// File: rtl/dag_pkg.sv
`timescale 1ns/1ps
package dag_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_PREDEC  = 2'd1,
    AM_POSTINC = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    PS_X   = 2'd0,
    PS_Y   = 2'd1,
    PS_Z   = 2'd2,
    PS_BAD = 2'd3
  } psel_e;
endpackage

// File: rtl/dag_ptr_bank.sv
`timescale 1ns/1ps
module dag_ptr_bank #(
  parameter int PTR_W    = 16,
  parameter int NPTR     = 3,
  parameter int REG_W    = 5,
  parameter int BASE_REG = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [REG_W-1:0]           ld_reg,
  input  logic [7:0]                 ld_byte,
  input  logic                       upd_en,
  input  logic [1:0]                 upd_sel,
  input  logic [PTR_W-1:0]           upd_val,
  output logic [NPTR-1:0][PTR_W-1:0] ptrs_o
);
  localparam int BPP   = PTR_W / 8;
  localparam int NBYTE = BPP * NPTR;

  logic [7:0] byte_q [NBYTE];
  logic       ld_hit;
  int         ld_off;

  always_comb begin
    ld_off = int'(ld_reg) - BASE_REG;
    ld_hit = ld_en && (ld_off >= 0) && (ld_off < NBYTE);
  end

  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[gb] <= 8'h00;
      end else if (upd_en && (int'(upd_sel) == gb / BPP)) begin
        byte_q[gb] <= upd_val[(gb % BPP)*8 +: 8];
      end else if (ld_hit && (ld_off == gb)) begin
        byte_q[gb] <= ld_byte;
      end
    end
  end

  for (genvar gp = 0; gp < NPTR; gp++) begin : g_ptr
    for (genvar gk = 0; gk < BPP; gk++) begin : g_pack
      assign ptrs_o[gp][gk*8 +: 8] = byte_q[gp*BPP + gk];
    end
  end

  AST_PTRS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !ld_hit) |=> $stable(ptrs_o)); // R3
endmodule

// File: rtl/dag_addr_calc.sv
`timescale 1ns/1ps
module dag_addr_calc
  import dag_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DISP_W = 6,
  parameter int NPTR   = 3
) (
  input  amode_e                     mode,
  input  logic [1:0]                 sel,
  input  logic [DISP_W-1:0]          disp,
  input  logic [NPTR-1:0][PTR_W-1:0] ptrs,
  output logic [PTR_W-1:0]           ea,
  output logic [PTR_W-1:0]           wb,
  output logic                       wb_en,
  output logic                       err
);
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p, input logic up);
    return up ? p + PTR_W'(1) : p - PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] add_disp(input logic [PTR_W-1:0] p,
                                                 input logic [DISP_W-1:0] q);
    return p + {{(PTR_W-DISP_W){1'b0}}, q};
  endfunction

  logic             sel_bad;
  logic             disp_x;
  logic [PTR_W-1:0] cur;

  always_comb begin
    sel_bad = (int'(sel) >= NPTR);
    disp_x  = (mode == AM_DISP) && (sel == PS_X);
    err     = sel_bad || disp_x;
    cur     = sel_bad ? '0 : ptrs[sel];
    ea      = cur;
    wb      = cur;
    wb_en   = 1'b0;
    if (err) begin
      ea = '0;
    end else begin
      unique case (mode)
        AM_PLAIN:   ;
        AM_PREDEC:  begin ea = step_ptr(cur, 1'b0); wb = ea; wb_en = 1'b1; end
        AM_POSTINC: begin wb = step_ptr(cur, 1'b1); wb_en = 1'b1; end
        AM_DISP:    ea = add_disp(cur, disp);
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/dag_top.sv
`timescale 1ns/1ps
module dag_top
  import dag_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int DISP_W   = 6,
  parameter int REG_W    = 5,
  parameter int BASE_REG = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              ld_en_i,
  input  logic [REG_W-1:0]  ld_reg_i,
  input  logic [7:0]        ld_byte_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [PTR_W-1:0]  ea_o,
  output logic [PTR_W-1:0]  wb_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o
);
  localparam int NPTR = 3;

  logic [NPTR-1:0][PTR_W-1:0] ptrs;
  logic [PTR_W-1:0]           c_ea, c_wb;
  logic                       c_wb_en, c_err;
  logic                       upd_fire;
  logic                       ld_allowed;

  assign upd_fire   = start_i && c_wb_en;
  assign ld_allowed = ld_en_i && !start_i;

  dag_ptr_bank #(
    .PTR_W(PTR_W), .NPTR(NPTR), .REG_W(REG_W), .BASE_REG(BASE_REG)
  ) i_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_allowed), .ld_reg(ld_reg_i), .ld_byte(ld_byte_i),
    .upd_en(upd_fire), .upd_sel(sel_i), .upd_val(c_wb),
    .ptrs_o(ptrs)
  );

  dag_addr_calc #(
    .PTR_W(PTR_W), .DISP_W(DISP_W), .NPTR(NPTR)
  ) i_calc (
    .mode(amode_e'(mode_i)), .sel(sel_i), .disp(disp_i), .ptrs(ptrs),
    .ea(c_ea), .wb(c_wb), .wb_en(c_wb_en), .err(c_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      ea_o     <= '0;
      wb_o     <= '0;
      wb_en_o  <= 1'b0;
      wb_sel_o <= 2'd0;
    end else if (start_i) begin
      valid_o  <= 1'b1;
      err_o    <= c_err;
      ea_o     <= c_ea;
      wb_o     <= c_wb;
      wb_en_o  <= c_wb_en;
      wb_sel_o <= sel_i;
    end else begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      wb_en_o  <= 1'b0;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o); // R9
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && $past(mode_i) == AM_PREDEC) |-> (wb_o == ea_o && wb_en_o)); // R5
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && $past(mode_i) == AM_POSTINC) |-> (wb_o == PTR_W'(ea_o + 1'b1))); // R6
  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (valid_o && !wb_en_o)); // R8
  AST_DISP_NOT_X: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && $past(mode_i) == AM_DISP) |-> ($past(sel_i) != PS_X && !wb_en_o)); // R7
endmodule

// File: tb/test_dag_top.sv
`timescale 1ns/1ps
module test_dag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  sel_i = 2'd0;
  logic [5:0]  disp_i = 6'd0;
  logic        ld_en_i = 1'b0;
  logic [4:0]  ld_reg_i = 5'd0;
  logic [7:0]  ld_byte_i = 8'd0;
  logic        valid_o, err_o, wb_en_o;
  logic [15:0] ea_o, wb_o;
  logic [1:0]  wb_sel_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [7:0] mb [6];

  always #5 clk = ~clk;

  dag_top i_dag_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .sel_i(sel_i),
    .disp_i(disp_i), .ld_en_i(ld_en_i), .ld_reg_i(ld_reg_i), .ld_byte_i(ld_byte_i),
    .valid_o(valid_o), .err_o(err_o), .ea_o(ea_o), .wb_o(wb_o),
    .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mp(input int s);
    return {mb[2*s+1], mb[2*s]};
  endfunction

  task automatic put(input int s, input logic [15:0] v);
    mb[2*s]   = v[7:0];
    mb[2*s+1] = v[15:8];
  endtask

  // one request; expectation from the bench model, model updated afterwards
  task automatic req(input logic [1:0] m, input logic [1:0] s, input logic [5:0] q, input string tag);
    logic [15:0] p, eea, ewb;
    logic        eerr, ewe;
    p    = (s == 2'd3) ? 16'h0 : mp(int'(s));
    eerr = (s == 2'd3) || (m == 2'd3 && s == 2'd0);
    ewe  = 1'b0; eea = p; ewb = p;
    if (eerr) eea = 16'h0;
    else case (m)
      2'd1: begin eea = p - 16'd1; ewb = eea; ewe = 1'b1; end
      2'd2: begin ewb = p + 16'd1; ewe = 1'b1; end
      2'd3: eea = p + {10'd0, q};
      default: ;
    endcase
    @(negedge clk);
    start_i = 1'b1; mode_i = m; sel_i = s; disp_i = q;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R9 valid"}, valid_o, 1);
    chk({tag, " R8 err"}, err_o, eerr);
    chk({tag, " ea"}, ea_o, eea);
    chk({tag, " wb_en"}, wb_en_o, ewe);
    chk({tag, " R9 wb_sel"}, wb_sel_o, s);
    if (!eerr) chk({tag, " wb"}, wb_o, ewb);
    if (ewe) put(int'(s), ewb);
  endtask

  task automatic load(input logic [4:0] r, input logic [7:0] b);
    @(negedge clk);
    ld_en_i = 1'b1; ld_reg_i = r; ld_byte_i = b;
    @(negedge clk);
    ld_en_i = 1'b0;
    if (r >= 5'd26) mb[int'(r) - 26] = b;
  endtask

  task automatic load_ptr(input int s, input logic [15:0] v);
    load(5'(26 + 2*s), v[7:0]);
    load(5'(27 + 2*s), v[15:8]);
  endtask

  task automatic t_reset();
    chk("R1 valid", valid_o, 0); chk("R1 err", err_o, 0);
    chk("R1 ea", ea_o, 0); chk("R1 wb", wb_o, 0); chk("R1 wb_en", wb_en_o, 0);
    for (int s = 0; s < 3; s++) req(2'd0, 2'(s), 6'd0, "R1 ptr zero");
  endtask

  task automatic t_load();
    load_ptr(0, 16'h1234); load_ptr(1, 16'hA000); load_ptr(2, 16'h00FF);
    req(2'd0, 2'd0, 6'd0, "R2 X"); req(2'd0, 2'd1, 6'd0, "R2 Y"); req(2'd0, 2'd2, 6'd0, "R2 Z");
    load(5'd31, 8'h7E);
    req(2'd0, 2'd2, 6'd0, "R2 high byte only");
  endtask

  task automatic t_load_ignored();
    load(5'd5, 8'hEE);
    load(5'd25, 8'hEE);
    req(2'd0, 2'd0, 6'd0, "R3 out of range");
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'd0; sel_i = 2'd0;
    ld_en_i = 1'b1; ld_reg_i = 5'd26; ld_byte_i = 8'h99;
    @(negedge clk);
    start_i = 1'b0; ld_en_i = 1'b0;
    chk("R3 collide ea", ea_o, mp(0));
    req(2'd0, 2'd0, 6'd0, "R3 load with start");
  endtask

  task automatic t_plain();
    req(2'd0, 2'd1, 6'd9, "R4 plain Y");
    req(2'd0, 2'd1, 6'd0, "R4 Y kept");
  endtask

  task automatic t_predec();
    req(2'd1, 2'd1, 6'd0, "R5 predec");
    req(2'd0, 2'd1, 6'd0, "R5 after");
    load_ptr(0, 16'h0000);
    req(2'd1, 2'd0, 6'd0, "R5 wrap");
    req(2'd0, 2'd0, 6'd0, "R5 wrap after");
  endtask

  task automatic t_postinc();
    req(2'd2, 2'd2, 6'd0, "R6 postinc");
    req(2'd0, 2'd2, 6'd0, "R6 after");
    load_ptr(2, 16'hFFFF);
    req(2'd2, 2'd2, 6'd0, "R6 wrap");
    req(2'd0, 2'd2, 6'd0, "R6 wrap after");
  endtask

  task automatic t_disp();
    req(2'd3, 2'd1, 6'd63, "R7 Y+63");
    req(2'd0, 2'd1, 6'd0, "R7 Y kept");
    load_ptr(2, 16'hFFF0);
    req(2'd3, 2'd2, 6'h20, "R7 Z wrap");
    req(2'd3, 2'd2, 6'd0, "R7 q zero");
  endtask

  task automatic t_err();
    req(2'd3, 2'd0, 6'd5, "R8 disp X");
    req(2'd2, 2'd3, 6'd0, "R8 bad sel");
    for (int s = 0; s < 3; s++) req(2'd0, 2'(s), 6'd0, "R8 untouched");
  endtask

  task automatic t_pulse();
    req(2'd0, 2'd0, 6'd0, "R9 single");
    @(negedge clk);
    chk("R9 pulse ends", valid_o, 0);
    req(2'd2, 2'd1, 6'd0, "R9 back to back a");
    req(2'd2, 2'd1, 6'd0, "R9 back to back b");
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      chk("R1 in reset valid", valid_o, 0);
      chk("R1 in reset ea", ea_o, 0);
    end
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_load_ignored();
    t_plain();
    t_predec();
    t_postinc();
    t_disp();
    t_err();
    t_pulse();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule